// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns characters written by a host into non-return-to-zero asynchronous frames on a single output line. It has two storage stages. A holding buffer accepts one character from the host. A shift register sends the previous character. The host can therefore queue the next character while the current one is still on the line. When a frame ends and a character is already waiting, the next frame starts with no idle time between them.

The bit time comes from the block's own divider, which runs on the peripheral clock. A 16-bit select value sets the divider, and a special case applies when that value is zero. The frame format is set by ports:

- character length, from 1 to 8 bits;
- parity, which can be none, odd or even;
- one or two stop bits;
- an optional address/data marker bit, used on multi-drop links.

The host sees three outputs: a buffer-ready flag, a shifter-empty flag, and an interrupt that has its own enable. A transmit enable starts and stops the flow of frames.

The control state machine has these states: IDLE, START, DATA, ADDR, PAR, STOP1 and STOP2. It moves between them as follows:

- IDLE to START when the transmit enable is set and the holding buffer is full. This transition is called "load".
- START to DATA after one bit time.
- DATA stays in DATA until the last data bit has been sent.
- DATA to ADDR when address mode is on.
- DATA or ADDR to PAR when parity is on.
- DATA, ADDR or PAR to STOP1 otherwise.
- STOP1 to STOP2 when two stop bits are selected.
- STOP1 or STOP2 to START when the frame ends, the enable is still set and the buffer is full. This transition is called "chain".
- STOP1 or STOP2 to IDLE at the end of a frame otherwise.

Top module: `async_serial_tx`

## Requirements
- R1: Every bit on `txd` lasts D clock cycles. D is 16 when `baud_sel` is 0, and (`baud_sel`+1)*8 otherwise.
- R2: `txd` is 1 when the line is idle. A frame is sent in this order:
  - a start bit of 0;
  - `char_len`+1 data bits, least significant bit first;
  - the address bit, if used;
  - the parity bit, if used;
  - stop bits of 1, two of them when `two_stop` is 1 and one otherwise.
- R3: `par_mode` selects the parity bit: 2'b01 gives odd parity, 2'b10 gives even parity, and 2'b00 or 2'b11 gives no parity bit. Parity is computed over the data bits sent plus the address bit when there is one.
- R4: While `tx_en` is 0, no frame starts and a buffered character is kept. If `tx_en` is cleared during a frame, that frame completes and `txd` then stays 1.
- R5: A write (`wr_valid`) is taken only when `buf_ready` is 1. A write made while `buf_ready` is 0 is ignored and never sent.
- R6: If a character is waiting when the last stop bit ends, its start bit follows at once. `buf_ready` returns to 1 when the waiting character moves into the shift register.
- R7: `shift_empty` is 1 only when the holding buffer is empty and no frame is in progress.
- R8: `irq` equals `irq_en` AND `buf_ready`.
- R9: When `addr_mode` is 1, an extra bit follows the last data bit. This bit is the value of `wr_addr` captured with the character: 1 marks an address, 0 marks data.
- R10: After reset, `txd`, `buf_ready` and `shift_empty` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable |
| irq_en | input | 1 | Interrupt enable |
| baud_sel | input | 16 | Bit-rate select value |
| char_len | input | 3 | Number of data bits minus one |
| par_mode | input | 2 | Parity select |
| two_stop | input | 1 | Selects two stop bits |
| addr_mode | input | 1 | Enables the address/data marker bit |
| wr_valid | input | 1 | Host write strobe |
| wr_data | input | 8 | Character to send |
| wr_addr | input | 1 | Marker value sent with this character |
| txd | output | 1 | Serial output line |
| buf_ready | output | 1 | Holding buffer can accept a character |
| shift_empty | output | 1 | Holding buffer and shifter are both empty |
| irq | output | 1 | Transmit interrupt |

## Verification
The line output is compared every clock against a reference model that builds each frame as a queue of bits and counts each bit time. Patterns with alternating bits and uneven bit counts (0xA5, 0x3C) show whether the bit order and the length mask are correct. The same data sent with odd and then even parity, and with the marker set and then cleared, separates the parity polarity from the marker placement. Three writes in quick succession, one of them ignored, together with enable drops before and during a frame, separate the no-gap hand-over from the dropped write and from the stop on frame completion.

// File: rtl/tx_pkg.sv
package tx_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_ADDR  = 3'd3,
        S_PAR   = 3'd4,
        S_STOP1 = 3'd5,
        S_STOP2 = 3'd6
    } tx_state_t;

    typedef enum logic [1:0] {
        PAR_OFF  = 2'b00,
        PAR_ODD  = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_OFF2 = 2'b11
    } par_mode_t;
endpackage

// File: rtl/tx_baud_gen.sv
module tx_baud_gen #(
    parameter int SEL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] baud_sel,
    output logic             tick
);
    localparam int CW = SEL_W + 4;

    logic [CW-1:0] cnt;
    logic [CW-1:0] sel_ext;
    logic [CW-1:0] div;

    assign sel_ext = CW'(baud_sel);
    assign div     = (baud_sel == '0) ? CW'(16) : ((sel_ext + CW'(1)) << 3);
    assign tick    = run && (cnt == div - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_addr,
    input  logic              load,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              abit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            abit <= 1'b0;
        end else if (load) begin
            full <= 1'b0;
        end else if (wr_valid && !full) begin
            full <= 1'b1;
            data <= wr_data;
            abit <= wr_addr;
        end
    end

    // R5
    wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !load) |=> ($stable(data) && full));
endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
    import tx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int LEN_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              tick,
    input  logic [LEN_W-1:0]  char_len,
    input  logic [1:0]        par_mode,
    input  logic              two_stop,
    input  logic              addr_mode,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_abit,
    output logic              load,
    output logic              busy,
    output logic              txd
);
    tx_state_t         state, nstate;
    logic [DATA_W-1:0] shreg;
    logic [LEN_W-1:0]  bidx;
    logic              abit_q, par_q;
    logic              par_on;
    logic [LEN_W:0]    nbits;
    logic [DATA_W:0]   mask;
    logic [DATA_W-1:0] masked;
    logic              xsum;
    tx_state_t         after_data, after_addr, frame_end;

    assign par_on = (par_mode == PAR_ODD) || (par_mode == PAR_EVEN);
    assign nbits  = {1'b0, char_len} + 1'b1;
    assign mask   = ({{DATA_W{1'b0}}, 1'b1} << nbits) - 1'b1;
    assign masked = hold_data & mask[DATA_W-1:0];
    assign xsum   = (^masked) ^ (addr_mode & hold_abit);

    always_comb begin
        after_addr = par_on ? S_PAR : S_STOP1;
        after_data = addr_mode ? S_ADDR : after_addr;
        frame_end  = (tx_en && hold_full) ? S_START : S_IDLE;
        nstate     = state;
        unique case (state)
            S_IDLE:  if (tx_en && hold_full) nstate = S_START;
            S_START: if (tick) nstate = S_DATA;
            S_DATA:  if (tick && bidx == char_len) nstate = after_data;
            S_ADDR:  if (tick) nstate = after_addr;
            S_PAR:   if (tick) nstate = S_STOP1;
            S_STOP1: if (tick) nstate = two_stop ? S_STOP2 : frame_end;
            S_STOP2: if (tick) nstate = frame_end;
            default: nstate = S_IDLE;
        endcase
        load = (nstate == S_START) && (state != S_START);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bidx   <= '0;
            abit_q <= 1'b0;
            par_q  <= 1'b0;
        end else if (load) begin
            shreg  <= masked;
            bidx   <= '0;
            abit_q <= hold_abit;
            par_q  <= (par_mode == PAR_ODD) ? ~xsum : xsum;
        end else if (state == S_DATA && tick) begin
            shreg  <= shreg >> 1;
            bidx   <= bidx + 1'b1;
        end
    end

    always_comb begin
        busy = (state != S_IDLE);
        unique case (state)
            S_IDLE:  txd = 1'b1;
            S_START: txd = 1'b0;
            S_DATA:  txd = shreg[0];
            S_ADDR:  txd = abit_q;
            S_PAR:   txd = par_q;
            S_STOP1: txd = 1'b1;
            S_STOP2: txd = 1'b1;
            default: txd = 1'b1;
        endcase
    end

    // R2
    start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START && !tick) |=> (state == S_START));

    // R4
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !tx_en) |=> (state == S_IDLE));

    // R6
    chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && state != S_IDLE) |=> (state == S_START && !$stable(bidx) || state == S_START));
endmodule

// File: rtl/async_serial_tx.sv
module async_serial_tx
    import tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 16,
    localparam int LEN_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              irq_en,
    input  logic [SEL_W-1:0]  baud_sel,
    input  logic [LEN_W-1:0]  char_len,
    input  logic [1:0]        par_mode,
    input  logic              two_stop,
    input  logic              addr_mode,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_addr,
    output logic              txd,
    output logic              buf_ready,
    output logic              shift_empty,
    output logic              irq
);
    logic              tick, load, busy, hold_full, hold_abit;
    logic [DATA_W-1:0] hold_data;

    tx_baud_gen #(.SEL_W(SEL_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(busy), .baud_sel(baud_sel), .tick(tick)
    );

    tx_hold_buf #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_addr(wr_addr), .load(load), .full(hold_full), .data(hold_data),
        .abit(hold_abit)
    );

    tx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tick(tick),
        .char_len(char_len), .par_mode(par_mode), .two_stop(two_stop),
        .addr_mode(addr_mode), .hold_full(hold_full), .hold_data(hold_data),
        .hold_abit(hold_abit), .load(load), .busy(busy), .txd(txd)
    );

    assign buf_ready   = ~hold_full;
    assign shift_empty = ~hold_full & ~busy;
    assign irq         = irq_en & ~hold_full;

    // R5
    wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && buf_ready) |=> !buf_ready);
endmodule

// File: tb/tb_async_serial_tx.sv
`timescale 1ns/1ps
module tb_async_serial_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, irq_en = 1'b1;
    logic [15:0] baud_sel = 16'd0;
    logic [2:0]  char_len = 3'd7;
    logic [1:0]  par_mode = 2'b00;
    logic        two_stop = 1'b0, addr_mode = 1'b0;
    logic        wr_valid = 1'b0, wr_addr = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        txd, buf_ready, shift_empty, irq;

    always #2 clk = ~clk;

    async_serial_tx dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_en(irq_en),
        .baud_sel(baud_sel), .char_len(char_len), .par_mode(par_mode),
        .two_stop(two_stop), .addr_mode(addr_mode), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_addr(wr_addr), .txd(txd),
        .buf_ready(buf_ready), .shift_empty(shift_empty), .irq(irq)
    );

    int    checks = 0, fails = 0;
    string phase = "R10";
    bit    done = 1'b0;

    bit       m_full, m_abit, m_busy, m_line, old_full, can_load;
    bit [7:0] m_data;
    int       q[$];
    int       rem;

    function automatic int bit_time();
        return (baud_sel == 16'd0) ? 16 : (int'(baud_sel) + 1) * 8;
    endfunction

    function automatic void build_frame();
        bit x = 1'b0;
        q.delete();
        for (int i = 0; i <= int'(char_len); i++) begin
            q.push_back(int'(m_data[i]));
            x ^= m_data[i];
        end
        if (addr_mode) begin
            q.push_back(int'(m_abit));
            x ^= m_abit;
        end
        if (par_mode == 2'b01) q.push_back(int'(!x));
        else if (par_mode == 2'b10) q.push_back(int'(x));
        q.push_back(1);
        if (two_stop) q.push_back(1);
        m_line = 1'b0;
        rem    = bit_time();
        m_busy = 1'b1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_full = 0; m_abit = 0; m_busy = 0; m_line = 1; m_data = 0; rem = 0;
            q.delete();
        end else begin
            old_full = m_full;
            can_load = 0;
            if (m_busy) begin
                rem--;
                if (rem == 0) begin
                    if (q.size() > 0) begin
                        m_line = q.pop_front() != 0;
                        rem    = bit_time();
                    end else begin
                        m_busy = 0; m_line = 1; can_load = 1;
                    end
                end
            end else can_load = 1;
            if (can_load && tx_en && old_full) begin
                build_frame();
                m_full = 0;
            end
            if (wr_valid && !old_full) begin
                m_full = 1; m_data = wr_data; m_abit = wr_addr;
            end
        end
    end

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(txd, m_line, phase, "txd");
            check(buf_ready, !m_full, "R5", "buf_ready");
            check(shift_empty, !m_full && !m_busy, "R7", "shift_empty");
            check(irq, irq_en && !m_full, "R8", "irq");
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_char(input logic [7:0] d, input logic a);
        wr_valid = 1'b1; wr_data = d; wr_addr = a;
        step(1);
        wr_valid = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000; i++) begin
            if (!m_busy && !m_full) break;
            step(1);
        end
        step(3);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R4 actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(4);
        tx_en = 1'b1;

        phase = "R1 R2";
        write_char(8'hA5, 1'b0);
        wait_done();

        phase = "R3";
        baud_sel = 16'd2; char_len = 3'd6; par_mode = 2'b10; two_stop = 1'b1;
        write_char(8'h3C, 1'b0);
        wait_done();
        par_mode = 2'b01;
        write_char(8'h3C, 1'b0);
        wait_done();
        par_mode = 2'b11; two_stop = 1'b0;
        write_char(8'h5B, 1'b0);
        wait_done();

        phase = "R9";
        baud_sel = 16'd1; char_len = 3'd7; par_mode = 2'b01; addr_mode = 1'b1;
        write_char(8'h81, 1'b1);
        wait_done();
        write_char(8'h81, 1'b0);
        wait_done();
        addr_mode = 1'b0; par_mode = 2'b00;

        phase = "R6";
        baud_sel = 16'd0;
        write_char(8'h11, 1'b0);
        step(3);
        write_char(8'hC3, 1'b0);
        write_char(8'hFF, 1'b0);
        wait_done();

        phase = "R4";
        tx_en = 1'b0;
        write_char(8'h6E, 1'b0);
        step(100);
        tx_en = 1'b1;
        step(30);
        write_char(8'h92, 1'b0);
        step(10);
        tx_en = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (!m_busy) break;
            step(1);
        end
        step(60);
        tx_en = 1'b1;
        wait_done();

        phase = "R8";
        irq_en = 1'b0;
        write_char(8'h0F, 1'b0);
        wait_done();
        irq_en = 1'b1;

        phase = "R2";
        baud_sel = 16'd5; char_len = 3'd0; two_stop = 1'b1;
        write_char(8'h01, 1'b0);
        wait_done();
        char_len = 3'd3;
        write_char(8'hF6, 1'b0);
        wait_done();

        finish_run();
    end
endmodule